// File: doc/BRIEF.md
# Exception Capture Unit

This block holds the exception-related system-control state of a small 32-bit load/store core. It watches two pipeline points in the same cycle: the instruction now executing and the address the fetch stage is about to read. It detects misaligned fetch and data addresses, instruction-fetch bus errors, and coprocessor instructions that are not allowed in the current privilege mode. When a fault is found it records where execution must resume, why it stopped, and which address was bad. It then pushes the privilege/interrupt-enable stack and asks the fetch stage to jump to the handler.

Only one fault is recorded per cycle. A fault from the executing instruction wins over a fetch fault, because that instruction is older. The fetch stage is told not to advance in any cycle where a fault is taken or where a redirect is in progress. The block is controlled by a two-state machine. `ST_RUN` is normal operation. The transition *take* (a fault is seen in `ST_RUN`) captures the registers and moves to `ST_REDIRECT`. `ST_REDIRECT` drives the handler address for one cycle, ignores all fault inputs, and goes back to `ST_RUN` through the transition *resume*. With no fault, `ST_RUN` stays in `ST_RUN` (*idle*).

Top module: `exc_capture_unit`

## Requirements
- R1: After reset, `epc_o`, `cause_o`, `badvaddr_o` and `mode_o` are all zero, `redirect_valid` is low and `redirect_pc` is zero.
- R2: For a fault of the executing instruction, `epc_o` becomes `ex_pc` minus 4 when `ex_in_delay` is high, and `ex_pc` otherwise. `cause_o` bit 31 becomes `ex_in_delay`. Bits 30, 27:7 and 1:0 of `cause_o` are always zero.
- R3: `cause_o[29:28]` receives `ex_cop_num` for an execute fault and zero for a fetch fault. Bit 31 is zero for a fetch fault.
- R4: On every taken fault, `mode_o` shifts left by two and the vacated bits 1:0 are zero. Bit 1 is the user flag and bit 0 is the interrupt enable.
- R5: A valid fetch with `if_pc[1:0]` not zero records code 4 in `cause_o[6:2]`. Both `epc_o` and `badvaddr_o` take `if_pc`. This holds even if `if_bus_err` is also high.
- R6: A valid, aligned fetch with `if_bus_err` high records code 6, with `epc_o` = `if_pc`. `badvaddr_o` is left unchanged.
- R7: An executing coprocessor instruction records code 11 and leaves `badvaddr_o` unchanged in three cases:
  - unit 0 is used while `mode_o[1]` is 1 and `st_cu0` is 0;
  - unit 2 is used while `mode_o[1]` is 1 and `st_cu2` is 0;
  - unit 3 is used, in any mode.
- R8: A data access is misaligned if it is halfword (size 1) with `addr[0]`=1, or word (size 2 or 3) with `addr[1:0]` not zero. Byte accesses (size 0) are never misaligned. A misaligned load records code 4 and a misaligned store records code 5, and `badvaddr_o` takes `ex_mem_addr`.
- R9: An execute fault has priority over a fetch fault in the same cycle. Within the execute stage, code 11 has priority over data misalignment.
- R10: In the cycle after a fault is taken, `redirect_valid` is high for exactly one cycle. `redirect_pc` is then 0xBFC00180 if `st_bev` was high when the fault was taken, and 0x80000080 otherwise.
- R11: `fetch_advance` is high exactly when `if_valid` is high, no redirect is in progress and no fault is taken in that cycle.
- R12: While `redirect_valid` is high, fault inputs are ignored: `epc_o`, `cause_o` and `badvaddr_o` keep their values over the next edge.
- R13: `mode_we` loads `mode_wd` into `mode_o` on the edge, unless a fault is taken on that same edge, in which case the shift of R4 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_valid | input | 1 | An instruction is executing this cycle |
| ex_pc | input | 32 | Address of the executing instruction |
| ex_in_delay | input | 1 | Executing instruction sits in a branch delay slot |
| ex_cop_use | input | 1 | Executing instruction is a coprocessor operation |
| ex_cop_num | input | 2 | Coprocessor-number field of the executing instruction |
| ex_mem_req | input | 1 | Executing instruction performs a data access |
| ex_mem_write | input | 1 | Data access is a store |
| ex_mem_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| ex_mem_addr | input | 32 | Data access address |
| if_valid | input | 1 | Fetch stage requests the next instruction |
| if_pc | input | 32 | Fetch address |
| if_bus_err | input | 1 | Bus error on the current fetch |
| st_cu0 | input | 1 | Coprocessor 0 usable in user mode |
| st_cu2 | input | 1 | Coprocessor 2 usable in user mode |
| st_bev | input | 1 | Boot exception vector select |
| mode_we | input | 1 | Load the mode stack |
| mode_wd | input | 6 | Value for the mode stack |
| epc_o | output | 32 | Recorded resume address |
| cause_o | output | 32 | Delay flag, coprocessor number, fault code |
| badvaddr_o | output | 32 | Recorded bad address |
| mode_o | output | 6 | Mode stack (old, previous, current pairs) |
| redirect_valid | output | 1 | Jump to handler this cycle |
| redirect_pc | output | 32 | Handler address, zero when no redirect |
| fetch_advance | output | 1 | Fetch stage may commit its address this cycle |

## Verification
The assertions assume three things about the surrounding pipeline:
- reset is released away from a clock edge;
- the fault inputs are settled before each rising edge;
- a mode write may land in any state, including `ST_REDIRECT`.

The stimulus sets every input shortly after a falling edge and holds it through the next rising edge. It combines directed cases for each fault kind, each priority and the vector select with a long stretch of mixed random inputs. In that stretch, fault conditions are frequent and often stack up, and they often arrive during `ST_REDIRECT`, which exercises the ignore rule.

// File: rtl/exc_pkg.sv
package exc_pkg;
    parameter int unsigned XLEN   = 32;
    parameter int unsigned MODE_W = 6;

    typedef enum logic [4:0] {
        EXC_NONE = 5'd0,
        EXC_ADEL = 5'd4,
        EXC_ADES = 5'd5,
        EXC_IBE  = 5'd6,
        EXC_CPU  = 5'd11
    } exc_code_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD3 = 2'd3
    } acc_size_t;

    typedef struct packed {
        exc_code_t       code;
        logic [XLEN-1:0] epc;
        logic            bd;
        logic [1:0]      ce;
        logic            bad_we;
        logic [XLEN-1:0] bad;
    } exc_rec_t;

    localparam int unsigned CAUSE_BD_BIT = 31;
    localparam int unsigned CAUSE_CE_LO  = 28;
    localparam int unsigned CAUSE_EC_LO  = 2;
endpackage

// File: rtl/exc_align_check.sv
module exc_align_check
    import exc_pkg::*;
#(
    parameter int unsigned LSB_W = 2
) (
    input  logic [LSB_W-1:0] addr_lsb,
    input  logic [1:0]       size,
    output logic             misaligned
);
    always_comb begin
        unique case (acc_size_t'(size))
            SZ_BYTE:          misaligned = 1'b0;
            SZ_HALF:          misaligned = addr_lsb[0];
            SZ_WORD, SZ_WRD3: misaligned = |addr_lsb;
            default:          misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_prio.sv
module exc_prio
    import exc_pkg::*;
#(
    parameter int unsigned AW = XLEN
) (
    input  logic          ex_valid,
    input  logic [AW-1:0] ex_pc,
    input  logic          ex_in_delay,
    input  logic          ex_cop_use,
    input  logic [1:0]    ex_cop_num,
    input  logic          ex_mem_req,
    input  logic          ex_mem_write,
    input  logic [1:0]    ex_mem_size,
    input  logic [AW-1:0] ex_mem_addr,
    input  logic          if_valid,
    input  logic [AW-1:0] if_pc,
    input  logic          if_bus_err,
    input  logic          user_mode,
    input  logic          cu0,
    input  logic          cu2,
    output logic          take,
    output exc_rec_t      rec
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(4);

    logic data_mis, fetch_mis, cop_bad;
    logic ex_fault, if_fault;

    exc_align_check #(.LSB_W(2)) u_data_align (
        .addr_lsb   (ex_mem_addr[1:0]),
        .size       (ex_mem_size),
        .misaligned (data_mis)
    );

    exc_align_check #(.LSB_W(2)) u_fetch_align (
        .addr_lsb   (if_pc[1:0]),
        .size       (SZ_WORD),
        .misaligned (fetch_mis)
    );

    always_comb begin
        unique case (ex_cop_num)
            2'd0:    cop_bad = user_mode && !cu0;
            2'd2:    cop_bad = user_mode && !cu2;
            2'd3:    cop_bad = 1'b1;
            default: cop_bad = 1'b0;
        endcase
    end

    always_comb begin
        rec      = '0;
        rec.code = EXC_NONE;
        ex_fault = 1'b0;
        if_fault = 1'b0;
        if (ex_valid) begin
            if (ex_cop_use && cop_bad) begin
                ex_fault = 1'b1;
                rec.code = EXC_CPU;
            end else if (ex_mem_req && data_mis) begin
                ex_fault   = 1'b1;
                rec.code   = ex_mem_write ? EXC_ADES : EXC_ADEL;
                rec.bad_we = 1'b1;
                rec.bad    = ex_mem_addr;
            end
        end
        if (ex_fault) begin
            rec.epc = ex_in_delay ? (ex_pc - WORD_BYTES) : ex_pc;
            rec.bd  = ex_in_delay;
            rec.ce  = ex_cop_num;
        end else if (if_valid) begin
            if (fetch_mis) begin
                if_fault   = 1'b1;
                rec.code   = EXC_ADEL;
                rec.bad_we = 1'b1;
                rec.bad    = if_pc;
                rec.epc    = if_pc;
            end else if (if_bus_err) begin
                if_fault = 1'b1;
                rec.code = EXC_IBE;
                rec.epc  = if_pc;
            end
        end
        take = ex_fault || if_fault;
    end
endmodule

// File: rtl/exc_csr.sv
module exc_csr
    import exc_pkg::*;
#(
    parameter int unsigned AW = XLEN,
    parameter int unsigned MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  exc_rec_t      rec,
    input  logic          mode_we,
    input  logic [MW-1:0] mode_wd,
    output logic [AW-1:0] epc_q,
    output logic [AW-1:0] cause_q,
    output logic [AW-1:0] bad_q,
    output logic [MW-1:0] mode_q
);
    logic [AW-1:0] cause_d;

    always_comb begin
        cause_d = '0;
        cause_d[CAUSE_BD_BIT]                = rec.bd;
        cause_d[CAUSE_CE_LO +: 2]            = rec.ce;
        cause_d[CAUSE_EC_LO +: $bits(exc_code_t)] = rec.code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
            bad_q   <= '0;
            mode_q  <= '0;
        end else if (capture) begin
            epc_q   <= rec.epc;
            cause_q <= cause_d;
            if (rec.bad_we) bad_q <= rec.bad;
            mode_q  <= {mode_q[MW-3:0], 2'b00};
        end else if (mode_we) begin
            mode_q  <= mode_wd;
        end
    end
endmodule

// File: rtl/exc_capture_unit.sv
module exc_capture_unit
    import exc_pkg::*;
#(
    parameter logic [31:0] VEC_NORMAL = 32'h8000_0080,
    parameter logic [31:0] VEC_BOOT   = 32'hBFC0_0180
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ex_valid,
    input  logic [31:0] ex_pc,
    input  logic        ex_in_delay,
    input  logic        ex_cop_use,
    input  logic [1:0]  ex_cop_num,
    input  logic        ex_mem_req,
    input  logic        ex_mem_write,
    input  logic [1:0]  ex_mem_size,
    input  logic [31:0] ex_mem_addr,
    input  logic        if_valid,
    input  logic [31:0] if_pc,
    input  logic        if_bus_err,
    input  logic        st_cu0,
    input  logic        st_cu2,
    input  logic        st_bev,
    input  logic        mode_we,
    input  logic [5:0]  mode_wd,
    output logic [31:0] epc_o,
    output logic [31:0] cause_o,
    output logic [31:0] badvaddr_o,
    output logic [5:0]  mode_o,
    output logic        redirect_valid,
    output logic [31:0] redirect_pc,
    output logic        fetch_advance
);
    localparam int unsigned KU_BIT = 1;

    typedef enum logic {ST_RUN, ST_REDIRECT} state_t;

    state_t      state_q, state_d;
    logic        take, capture;
    exc_rec_t    rec;
    logic [31:0] vec_q;

    exc_prio #(.AW(32)) u_prio (
        .ex_valid     (ex_valid),
        .ex_pc        (ex_pc),
        .ex_in_delay  (ex_in_delay),
        .ex_cop_use   (ex_cop_use),
        .ex_cop_num   (ex_cop_num),
        .ex_mem_req   (ex_mem_req),
        .ex_mem_write (ex_mem_write),
        .ex_mem_size  (ex_mem_size),
        .ex_mem_addr  (ex_mem_addr),
        .if_valid     (if_valid),
        .if_pc        (if_pc),
        .if_bus_err   (if_bus_err),
        .user_mode    (mode_o[KU_BIT]),
        .cu0          (st_cu0),
        .cu2          (st_cu2),
        .take         (take),
        .rec          (rec)
    );

    exc_csr #(.AW(32), .MW(6)) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .rec     (rec),
        .mode_we (mode_we),
        .mode_wd (mode_wd),
        .epc_q   (epc_o),
        .cause_q (cause_o),
        .bad_q   (badvaddr_o),
        .mode_q  (mode_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (capture) vec_q <= st_bev ? VEC_BOOT : VEC_NORMAL;
        end
    end

    // next state and outputs
    always_comb begin
        state_d        = state_q;
        capture        = 1'b0;
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        fetch_advance  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                capture       = take;
                fetch_advance = if_valid && !take;
                if (take) state_d = ST_REDIRECT;   // take
            end
            ST_REDIRECT: begin
                redirect_valid = 1'b1;
                redirect_pc    = vec_q;
                state_d        = ST_RUN;           // resume
            end
            default: state_d = ST_RUN;
        endcase
    end
endmodule

// File: rtl/exc_capture_sva.sv
module exc_capture_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        redirect_valid,
    input logic [31:0] redirect_pc,
    input logic        fetch_advance,
    input logic [31:0] epc,
    input logic [31:0] cause,
    input logic [31:0] badv,
    input logic [1:0]  kmode
);
    AST_ONE_CYCLE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);                                   // R10
    AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (redirect_pc == 32'h8000_0080 || redirect_pc == 32'hBFC0_0180)); // R10
    AST_FROZEN_IN_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> ($stable(epc) && $stable(cause) && $stable(badv))); // R12
    AST_KERNEL_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (kmode == 2'b00));                                  // R4
    AST_NO_ADVANCE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> !fetch_advance);                                    // R11
    AST_CAUSE_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cause & 32'h4FFF_FF83) == 32'h0);                                     // R2
    AST_FETCH_FAULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && cause[6:2] == 5'd6) |-> (cause[31:28] == 4'h0));    // R3
endmodule

bind exc_capture_unit exc_capture_sva u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .fetch_advance  (fetch_advance),
    .epc            (epc_o),
    .cause          (cause_o),
    .badv           (badvaddr_o),
    .kmode          (mode_o[1:0])
);

// File: tb/exc_capture_unit_test.sv
`timescale 1ns/1ps
module exc_capture_unit_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ex_valid = 0, ex_in_delay = 0, ex_cop_use = 0, ex_mem_req = 0, ex_mem_write = 0;
    logic [31:0] ex_pc = 0, ex_mem_addr = 0, if_pc = 0;
    logic [1:0] ex_cop_num = 0, ex_mem_size = 0;
    logic if_valid = 0, if_bus_err = 0, st_cu0 = 0, st_cu2 = 0, st_bev = 0, mode_we = 0;
    logic [5:0] mode_wd = 0;
    logic [31:0] epc_o, cause_o, badvaddr_o, redirect_pc;
    logic [5:0] mode_o;
    logic redirect_valid, fetch_advance;

    int vectors = 0, errors = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_epc, m_cause, m_bad, m_vec;
    logic [5:0]  m_mode;
    bit          m_redir;

    always #10 clk = ~clk;   // 50 MHz

    exc_capture_unit uut (.*);

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural model of one cycle's decision
    task automatic decide(output bit tk, output logic [31:0] e, output logic [31:0] c,
                          output bit bwe, output logic [31:0] b);
        int code = 0; bit exf = 0; bit user; bit mis;
        tk = 0; e = 0; c = 0; bwe = 0; b = 0;
        user = m_mode[1];
        if (m_redir) return;
        if (ex_valid) begin
            if (ex_cop_use && ((ex_cop_num == 0 && user && !st_cu0) ||
                               (ex_cop_num == 2 && user && !st_cu2) || ex_cop_num == 3)) begin
                exf = 1; code = 11;
            end else if (ex_mem_req) begin
                case (ex_mem_size)
                    0: mis = 0;
                    1: mis = ex_mem_addr[0];
                    default: mis = (ex_mem_addr % 4) != 0;
                endcase
                if (mis) begin exf = 1; code = ex_mem_write ? 5 : 4; bwe = 1; b = ex_mem_addr; end
            end
        end
        if (exf) begin
            tk = 1;
            e = ex_in_delay ? ex_pc - 4 : ex_pc;
            c = (ex_in_delay ? 32'h8000_0000 : 0) + (32'(ex_cop_num) << 28) + (32'(code) << 2);
        end else if (if_valid && (if_pc % 4) != 0) begin
            tk = 1; e = if_pc; c = 4 << 2; bwe = 1; b = if_pc;
        end else if (if_valid && if_bus_err) begin
            tk = 1; e = if_pc; c = 6 << 2;
        end
    endtask

    // one clock: inputs are already set after a falling edge
    task automatic cycle(string tag);
        bit tk, bwe; logic [31:0] e, c, b; bit adv;
        #2;
        decide(tk, e, c, bwe, b);
        adv = !m_redir && if_valid && !tk;
        chk("R11", {tag, " fetch_advance"}, 32'(fetch_advance), 32'(adv));
        @(posedge clk);
        if (tk) begin
            m_epc = e; m_cause = c; if (bwe) m_bad = b;
            m_mode = {m_mode[3:0], 2'b00};
            m_vec = st_bev ? 32'hBFC0_0180 : 32'h8000_0080;
            m_redir = 1;
        end else begin
            m_redir = 0;
            if (mode_we) m_mode = mode_wd;
        end
        @(negedge clk);
        chk("R2",  {tag, " epc"},      epc_o, m_epc);
        chk("R3",  {tag, " cause"},    cause_o, m_cause);
        chk("R5",  {tag, " badvaddr"}, badvaddr_o, m_bad);
        chk("R4",  {tag, " mode"},     32'(mode_o), 32'(m_mode));
        chk("R10", {tag, " redirect"}, 32'(redirect_valid), 32'(m_redir));
        chk("R10", {tag, " vector"},   redirect_pc, m_redir ? m_vec : 32'h0);
    endtask

    task automatic quiet();
        ex_valid = 0; ex_in_delay = 0; ex_cop_use = 0; ex_mem_req = 0; ex_mem_write = 0;
        if_valid = 0; if_bus_err = 0; mode_we = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; vectors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        m_epc = 0; m_cause = 0; m_bad = 0; m_vec = 0; m_mode = 0; m_redir = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "epc", epc_o, 0);        chk("R1", "cause", cause_o, 0);
        chk("R1", "bad", badvaddr_o, 0);   chk("R1", "mode", 32'(mode_o), 0);
        chk("R1", "redirect", 32'(redirect_valid), 0); chk("R1", "vector", redirect_pc, 0);

        // R11 plain fetch advances
        if_valid = 1; if_pc = 32'h100; cycle("R11 clean fetch");
        // R5 misaligned fetch, with bus error also high
        if_pc = 32'h102; if_bus_err = 1; mode_we = 0; cycle("R5 fetch misalign");
        quiet(); cycle("R12 redirect slot");
        // R6 fetch bus error keeps badvaddr
        if_valid = 1; if_pc = 32'h200; if_bus_err = 1; cycle("R6 fetch bus error");
        quiet(); cycle("R10 redirect");
        // R13 mode load into user mode, then R7 cop2 unusable in delay slot
        mode_we = 1; mode_wd = 6'b001111; cycle("R13 mode load");
        quiet(); ex_valid = 1; ex_pc = 32'h400; ex_in_delay = 1; ex_cop_use = 1; ex_cop_num = 2;
        st_bev = 1; cycle("R7 cop2 user");
        quiet(); st_bev = 0; cycle("R10 boot vector");
        // R7 cop3 in kernel mode still faults
        ex_valid = 1; ex_pc = 32'h500; ex_cop_use = 1; ex_cop_num = 3; cycle("R7 cop3 kernel");
        quiet(); cycle("R12 after cop3");
        // R8 byte never misaligned; halfword and word stores
        ex_valid = 1; ex_mem_req = 1; ex_mem_size = 0; ex_mem_addr = 32'h33; cycle("R8 byte");
        ex_mem_size = 1; ex_mem_addr = 32'h42; cycle("R8 half aligned");
        ex_mem_write = 1; ex_mem_addr = 32'h43; ex_pc = 32'h600; cycle("R8 half store");
        quiet(); cycle("R12 after store");
        // R9 execute over fetch; CpU over alignment
        ex_valid = 1; ex_pc = 32'h700; ex_mem_req = 1; ex_mem_size = 2; ex_mem_addr = 32'h81;
        ex_cop_use = 1; ex_cop_num = 3; if_valid = 1; if_pc = 32'h903; cycle("R9 priority");
        // R12 faults during redirect are ignored
        cycle("R12 ignored");
        quiet(); cycle("R9 settle");
        // R13 mode write loses to a fault on the same edge
        mode_we = 1; mode_wd = 6'b000010; if_valid = 1; if_pc = 32'hA01; cycle("R13 collide");
        quiet(); cycle("R13 settle");

        // mixed random stretch
        for (int i = 0; i < 3000; i++) begin
            ex_valid     = $urandom_range(0, 1);
            ex_pc        = $urandom & 32'hFFFF_FFFC;
            ex_in_delay  = $urandom_range(0, 1);
            ex_cop_use   = ($urandom_range(0, 3) == 0);
            ex_cop_num   = 2'($urandom);
            ex_mem_req   = $urandom_range(0, 1);
            ex_mem_write = $urandom_range(0, 1);
            ex_mem_size  = 2'($urandom);
            ex_mem_addr  = $urandom;
            if_valid     = $urandom_range(0, 1);
            if_pc        = ($urandom_range(0, 2) == 0) ? $urandom : ($urandom & 32'hFFFF_FFFC);
            if_bus_err   = ($urandom_range(0, 4) == 0);
            st_cu0       = $urandom_range(0, 1);
            st_cu2       = $urandom_range(0, 1);
            st_bev       = $urandom_range(0, 1);
            mode_we      = ($urandom_range(0, 3) == 0);
            mode_wd      = 6'($urandom);
            cycle("R9 mixed");
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule